// File: doc/BRIEF.md
# Dual-Channel Spectrum Reorder Buffer

This block sits after a streaming radix-2 FFT that transforms two complex channels at once and returns its results in bit-reversed order. Each block of N results arrives two bins per clock on a pair of ports, X and Y. For the first N/2 cycles the pair carries channel A's spectrum, and for the next N/2 cycles it carries channel B's. The buffer separates the two spectra and puts them in natural order. Channel A leaves on one output port and channel B on the other, bin for bin in the same cycle, with a pulse marking bin 0.

Storage is arranged as ping-pong banks. One block is written in scrambled order while the previous complete block is read out sequentially. For every channel, the bins whose index has a clear top bit and the bins whose index has that bit set go to separate memories. As a result, each memory receives at most one write per cycle and can map onto a simple dual-port block RAM.

The buffer keeps track of whether the incoming sync stream is regular. After reset, after a block boundary that brings no sync, or after a sync that arrives in the middle of a block, the next block is taken as unreliable and is not emitted. The block after it is emitted.

Top module: `bin_reorder_2ch`

## Requirements
- R1: Input cycle k of a block (k = 0 on the cycle `in_sync` is high) carries channel A when k < N/2 and channel B otherwise. With j = k mod N/2, X carries bin rev(2j) and Y carries bin rev(2j+1), where rev reverses the LOG2N-bit index.
- R2: An emitted block shows channel A on `out_a_*` and channel B on `out_b_*`. Bins 0, 1, ..., N-1 appear on N consecutive cycles, both channels showing the same bin in the same cycle.
- R3: `out_sync` is high exactly on the cycle that shows bin 0 of an emitted block. That cycle comes N+2 cycles after the `in_sync` cycle that started the block.
- R4: When complete blocks arrive back to back with a sync every N cycles, every block after the first is emitted and `out_sync` pulses every N cycles. Two output syncs are never less than N cycles apart.
- R5: After reset, the first complete block is discarded. Bin data is first emitted for the second block, which must start on the cycle right after the first block ends.
- R6: If no sync arrives on the cycle after a block ends, that block is still emitted in full. No further `out_sync` follows, and the next block that starts with a sync is discarded.
- R7: A sync that arrives before a block has received all N cycles abandons that block and never emits it. The block started by that sync is discarded, and the block after it, if adjacent, is emitted.
- R8: While `rst` is high, and on the cycle after, `out_sync` is low. A block whose output had not yet started when reset was applied is never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_sync | input | 1 | High on the first cycle of an input block |
| in_x_re | input | W | X port, real part |
| in_x_im | input | W | X port, imaginary part |
| in_y_re | input | W | Y port, real part |
| in_y_im | input | W | Y port, imaginary part |
| out_sync | output | 1 | High on the cycle carrying bin 0 |
| out_a_re | output | W | Channel A, real part, natural order |
| out_a_im | output | W | Channel A, imaginary part, natural order |
| out_b_re | output | W | Channel B, real part, natural order |
| out_b_im | output | W | Channel B, imaginary part, natural order |

## Verification
On every cycle the assertions check the timing of `out_sync`. No two output pulses may be closer than N cycles. No pulse may come before two input syncs have been seen since reset, or more than N+2 cycles after the most recent input sync. Reset must silence the pulse. None of these covers the data itself: the routing of each scrambled bin to the right channel and position, and the choice of which blocks are dropped after an irregular sync pattern. Only the bench's scenarios show those, by comparing every output bin with its reference model across back-to-back streams, gaps, truncated blocks and a reset that falls while output is pending.

// File: rtl/reorder_pkg.sv
package reorder_pkg;
  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} chan_e;
  localparam int NUM_CH   = 2;
  localparam int NUM_HALF = 2;
endpackage

// File: rtl/reorder_ram.sv
module reorder_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/reorder_ctrl.sv
module reorder_ctrl
  import reorder_pkg::*;
#(
  parameter int LOG2N = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_sync,
  output logic             wr_en,
  output chan_e            wr_chan,
  output logic [LOG2N-1:0] wr_addr,
  output logic [LOG2N-1:0] rd_addr,
  output logic             rd_half,
  output logic             rd_first
);
  localparam int N  = 1 << LOG2N;
  localparam int HB = LOG2N - 1;

  logic [LOG2N-1:0] wcnt, rcnt, widx;
  logic             wact, locked, wbank, ract, rbank;
  logic             last_w, publish;
  logic [HB-1:0]    rev_idx;

  assign widx    = in_sync ? '0 : wcnt;
  assign wr_en   = in_sync | wact;
  assign last_w  = wr_en && (widx == LOG2N'(N - 1));
  assign publish = last_w && locked;

  // index reversal of the lower bits: bin rev(2j) and rev(2j+1) share it
  for (genvar i = 0; i < HB; i++) begin : g_rev
    assign rev_idx[i] = widx[HB-1-i];
  end

  assign wr_chan  = chan_e'(widx[HB]);
  assign wr_addr  = {wbank, rev_idx};
  assign rd_addr  = {rbank, rcnt[HB-1:0]};
  assign rd_half  = rcnt[HB];
  assign rd_first = ract && (rcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt   <= '0;
      wact   <= 1'b0;
      locked <= 1'b0;
      wbank  <= 1'b0;
      rcnt   <= '0;
      ract   <= 1'b0;
      rbank  <= 1'b0;
    end else begin
      if (wr_en && !last_w) begin
        wact <= 1'b1;
        wcnt <= widx + 1'b1;
      end else begin
        wact <= 1'b0;
        wcnt <= '0;
      end

      if (last_w)
        locked <= 1'b1;
      else if (!wr_en || (in_sync && wact))
        locked <= 1'b0;

      if (publish) begin
        ract  <= 1'b1;
        rcnt  <= '0;
        rbank <= wbank;
        wbank <= ~wbank;
      end else if (ract) begin
        rcnt <= rcnt + 1'b1;
        if (rcnt == LOG2N'(N - 1)) ract <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bin_reorder_2ch.sv
module bin_reorder_2ch
  import reorder_pkg::*;
#(
  parameter int LOG2N = 6,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_sync,
  input  logic [W-1:0] in_x_re,
  input  logic [W-1:0] in_x_im,
  input  logic [W-1:0] in_y_re,
  input  logic [W-1:0] in_y_im,
  output logic         out_sync,
  output logic [W-1:0] out_a_re,
  output logic [W-1:0] out_a_im,
  output logic [W-1:0] out_b_re,
  output logic [W-1:0] out_b_im
);
  localparam int DW = 2 * W;

  logic             wr_en, rd_half, rd_first;
  chan_e            wr_chan;
  logic [LOG2N-1:0] wr_addr, rd_addr;
  logic             half_q, first_q;
  logic [DW-1:0]    rdata [NUM_CH][NUM_HALF];
  logic [DW-1:0]    sel   [NUM_CH];

  reorder_ctrl #(.LOG2N(LOG2N)) u_ctrl (
    .clk(clk), .rst(rst), .in_sync(in_sync),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_half(rd_half), .rd_first(rd_first)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
      logic          we_h;
      logic [DW-1:0] wd_h;
      assign we_h = wr_en && (wr_chan == chan_e'(c));
      if (h == 0) begin : g_lo
        assign wd_h = {in_x_re, in_x_im};
      end else begin : g_hi
        assign wd_h = {in_y_re, in_y_im};
      end
      reorder_ram #(.AW(LOG2N), .DW(DW)) u_ram (
        .clk(clk), .we(we_h), .waddr(wr_addr), .wdata(wd_h),
        .raddr(rd_addr), .rdata(rdata[c][h])
      );
    end
    assign sel[c] = half_q ? rdata[c][1] : rdata[c][0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q   <= 1'b0;
      first_q  <= 1'b0;
      out_sync <= 1'b0;
    end else begin
      half_q   <= rd_half;
      first_q  <= rd_first;
      out_sync <= first_q;
    end
  end

  always_ff @(posedge clk) begin
    {out_a_re, out_a_im} <= sel[0];
    {out_b_re, out_b_im} <= sel[1];
  end
endmodule

// File: rtl/reorder_checks.sv
module reorder_checks #(
  parameter int LOG2N = 6
) (
  input logic clk,
  input logic rst,
  input logic in_sync,
  input logic out_sync
);
  localparam int N  = 1 << LOG2N;
  localparam int CW = LOG2N + 3;

  logic [CW-1:0] gap_cnt, since_in;
  logic          seen_out;
  logic [1:0]    syncs_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      seen_out <= 1'b0;
      since_in <= CW'(N + 3);
      syncs_in <= 2'd0;
    end else begin
      if (out_sync) begin
        gap_cnt  <= '0;
        seen_out <= 1'b1;
      end else if (gap_cnt < CW'(N)) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
      if (in_sync) begin
        since_in <= '0;
        if (syncs_in != 2'd2) syncs_in <= syncs_in + 1'b1;
      end else if (since_in < CW'(N + 3)) begin
        since_in <= since_in + 1'b1;
      end
    end
  end

  assert_sync_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (out_sync && seen_out) |-> (gap_cnt >= CW'(N - 1)));

  assert_first_block_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> (syncs_in == 2'd2));

  assert_no_sync_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> (since_in <= CW'(N + 1)));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> !out_sync);
endmodule

bind bin_reorder_2ch reorder_checks #(.LOG2N(LOG2N)) u_chk (
  .clk(clk), .rst(rst), .in_sync(in_sync), .out_sync(out_sync)
);

// File: tb/sim_bin_reorder_2ch.sv
`timescale 1ns/1ps
module sim_bin_reorder_2ch;
  localparam int L = 4;
  localparam int N = 1 << L;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst, in_sync, out_sync;
  logic [W-1:0] in_x_re, in_x_im, in_y_re, in_y_im;
  logic [W-1:0] out_a_re, out_a_im, out_b_re, out_b_im;

  bin_reorder_2ch #(.LOG2N(L), .W(W)) u0 (
    .clk(clk), .rst(rst), .in_sync(in_sync),
    .in_x_re(in_x_re), .in_x_im(in_x_im), .in_y_re(in_y_re), .in_y_im(in_y_im),
    .out_sync(out_sync),
    .out_a_re(out_a_re), .out_a_im(out_a_im), .out_b_re(out_b_re), .out_b_im(out_b_im)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0, nsync_obs = 0, last_end = -100;
  int exp_id  [int];
  int exp_bin [int];

  function automatic int brev(int v);
    int r = 0;
    for (int i = 0; i < L; i++) if (v[i]) r |= 1 << (L - 1 - i);
    return r;
  endfunction

  function automatic logic [W-1:0] vre(int id, int ch, int b);
    return W'(id * 97 + ch * 61 + b * 5 + 3);
  endfunction

  function automatic logic [W-1:0] vim(int id, int ch, int b);
    return W'((id * 13) ^ (ch * 4001) ^ (b * 211));
  endfunction

  // reference: compare outputs with the scheduled expectation every cycle
  always @(negedge clk) begin
    if (cyc >= 2) begin
      logic es;
      es = exp_bin.exists(cyc) && (exp_bin[cyc] == 0);
      total++;
      if (out_sync !== es) begin
        bad++;
        $display("FAIL R3 cycle %0d out_sync actual=%b expected=%b", cyc, out_sync, es);
      end
      if (exp_id.exists(cyc)) begin
        int id, b;
        id = exp_id[cyc]; b = exp_bin[cyc];
        total++;
        if (out_a_re !== vre(id, 0, b) || out_a_im !== vim(id, 0, b) ||
            out_b_re !== vre(id, 1, b) || out_b_im !== vim(id, 1, b)) begin
          bad++;
          $display("FAIL R1 R2 cycle %0d bin %0d actual=%h %h %h %h expected=%h %h %h %h",
                   cyc, b, out_a_re, out_a_im, out_b_re, out_b_im,
                   vre(id, 0, b), vim(id, 0, b), vre(id, 1, b), vim(id, 1, b));
        end
      end
      if (out_sync === 1'b1) nsync_obs++;
    end
  end

  task automatic set_in(bit s, int id, int k);
    int ch, j;
    ch = k / (N / 2);
    j  = k % (N / 2);
    in_sync = s;
    in_x_re = vre(id, ch, brev(2 * j));
    in_x_im = vim(id, ch, brev(2 * j));
    in_y_re = vre(id, ch, brev(2 * j + 1));
    in_y_im = vim(id, ch, brev(2 * j + 1));
  endtask

  task automatic run_block(int id, int len);
    int s;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 0) begin
        s = cyc;
        if (len == N) begin
          if (last_end == s - 1)
            for (int n = 0; n < N; n++) begin
              exp_id[s + N + 2 + n]  = id;
              exp_bin[s + N + 2 + n] = n;
            end
          last_end = s + N - 1;
        end
      end
      set_in(k == 0, id, k);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_sync = 1'b0;
      in_x_re = '0; in_x_im = '0; in_y_re = '0; in_y_im = '0;
    end
  endtask

  task automatic check_count(string tag, int got, int want);
    total++;
    if (got != want) begin
      bad++;
      $display("FAIL %s output sync count actual=%0d expected=%0d", tag, got, want);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int c0;
    rst = 1'b1;
    in_sync = 1'b0;
    in_x_re = '0; in_x_im = '0; in_y_re = '0; in_y_im = '0;
    repeat (4) @(negedge clk);
    total++;
    if (out_sync !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset state out_sync actual=%b expected=0", out_sync);
    end
    rst = 1'b0;

    // R4 R5: back-to-back stream, first block dropped, then gap (R6)
    c0 = nsync_obs;
    for (int b = 1; b <= 4; b++) run_block(b, N);
    idle(2 * N + 8);
    check_count("R5", nsync_obs - c0, 3);

    // R6: resync after the gap drops one block
    c0 = nsync_obs;
    run_block(5, N);
    run_block(6, N);
    idle(2 * N + 8);
    check_count("R6", nsync_obs - c0, 1);

    // R7: truncated block in the middle of a stream
    c0 = nsync_obs;
    run_block(10, N);
    run_block(11, N);
    run_block(12, 5);
    run_block(13, N);
    run_block(14, N);
    idle(2 * N + 8);
    check_count("R7", nsync_obs - c0, 2);

    // R4: longer continuous stream
    c0 = nsync_obs;
    for (int b = 30; b < 36; b++) run_block(b, N);
    idle(2 * N + 8);
    check_count("R4", nsync_obs - c0, 5);

    // R8: reset while a block is waiting to be emitted
    c0 = nsync_obs;
    run_block(20, N);
    run_block(21, N);
    @(negedge clk);
    rst = 1'b1;
    in_sync = 1'b0;
    exp_id.delete();
    exp_bin.delete();
    last_end = -100;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2 * N + 8);
    check_count("R8", nsync_obs - c0, 0);

    finish_run();
  end
endmodule